// File: doc/BRIEF.md
# DRAM Self-Refresh Entry/Exit Sequencer

This block walks a DRAM into and out of its low-power self-refresh state on behalf of a memory controller. When the system asks it to sleep, it issues a single refresh command in a cycle with clock-enable held low. From then on the device keeps its contents without outside help, and the sequencer ignores everything except a wake request.

On wake, the sequencer keeps clock-enable low until the clock-stable input has been seen high for a set run of consecutive cycles. It then raises clock-enable and drives only NOPs until the exit recovery time has passed. At that point it reports that general commands may be issued again. A second, longer timer covers the device's delay-locked loop, which must relock. READs are reported as allowed only once that timer has expired, 200 cycles after clock-enable rose.

The controller uses two flags. `cmd_ready_o` gates all of its own commands, and `read_ready_o` additionally gates READs. The command code is a 3-bit {RAS#, CAS#, WE#} value with chip select taken as asserted.

Top module: `selfref_seq`

## Requirements
- R1: After reset the block is in its normal state: `cke_o`=1, `cmd_o`=NOP (3'b111), `cmd_ready_o`=1, `read_ready_o`=1.
- R2: A `sleep_req_i` sampled in the normal state, or in the ready-but-no-read state, yields exactly one following cycle with `cmd_o`=REFRESH (3'b001), `cke_o`=0 and both ready flags 0.
- R3: After the entry cycle `cke_o` stays 0, `cmd_o` is NOP and both ready flags are 0. `sleep_req_i` and `clk_stable_i` have no effect until `wake_req_i` is sampled.
- R4: After a wake, `cke_o` stays 0 until `clk_stable_i` has been sampled high on STABLE_CYCLES (default 4) consecutive cycles, counted from the cycle after the wake. Any low sample restarts the count. `cke_o` rises in the cycle after the last high sample.
- R5: For the first EXIT_NOP_CYCLES (default 10) cycles with `cke_o`=1 after the exit, `cmd_o` is NOP and `cmd_ready_o` is 0.
- R6: `cmd_ready_o` returns to 1 in the cycle after those EXIT_NOP_CYCLES cycles, while `read_ready_o` is still 0.
- R7: `read_ready_o` returns to 1 only after DLL_CYCLES (default 200) cycles with `cke_o`=1 since the exit. `read_ready_o`=1 always implies `cmd_ready_o`=1 and `cke_o`=1.
- R8: `wake_req_i` has no effect in the normal state. `sleep_req_i` has no effect while waiting for the clock or during the NOP-only window.
- R9: `cmd_o` only ever takes the NOP or REFRESH codes.
- R10: A sleep request accepted before reads are re-enabled starts a new entry. The next exit again waits the full DLL_CYCLES before `read_ready_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Request to enter self-refresh |
| wake_req_i | input | 1 | Request to leave self-refresh |
| clk_stable_i | input | 1 | DRAM clock reported stable |
| cke_o | output | 1 | DRAM clock-enable |
| cmd_o | output | 3 | DRAM command {RAS#, CAS#, WE#} |
| cmd_ready_o | output | 1 | Non-READ commands may be issued |
| read_ready_o | output | 1 | READ commands may be issued |

## Verification
On every cycle the assertions check the following. A refresh code is followed by a cycle with clock-enable still low. Clock-enable never rises without a stable-clock sample just before it. No ready flag is ever up while clock-enable is low. Counted against a cycle counter in the checker, neither ready flag rises earlier than its recovery window allows. Only the bench's scenarios show that the windows end on exactly the right cycle, that a glitch on the stable input restarts the qualification, that requests arriving in the wrong state have no effect, and that a re-entry during the read lockout restarts the full DLL window.

// File: rtl/selfref_pkg.sv
package selfref_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_ENTER,
    ST_SELF_REFRESH,
    ST_WAIT_CLK,
    ST_EXIT_NOP,
    ST_READY
  } sr_state_e;

  // {ras_n, cas_n, we_n}, chip select asserted
  typedef enum logic [2:0] {
    CMD_REFRESH = 3'b001,
    CMD_NOP     = 3'b111
  } dram_cmd_e;
endpackage

// File: rtl/sr_clk_qualifier.sv
module sr_clk_qualifier #(
  parameter int unsigned STABLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stable_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !stable_i) cnt_q <= '0;
    else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
  end

  // true on the STABLE_CYCLES-th consecutive high sample
  assign ok_o = en_i && stable_i && (cnt_q == LAST);
endmodule

// File: rtl/sr_exit_timer.sv
module sr_exit_timer #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // high in the LIMIT-th running cycle
  assign last_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/selfref_seq.sv
module selfref_seq
  import selfref_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES   = 4,
  parameter int unsigned EXIT_NOP_CYCLES = 10,
  parameter int unsigned DLL_CYCLES      = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  input  logic       clk_stable_i,
  output logic       cke_o,
  output logic [2:0] cmd_o,
  output logic       cmd_ready_o,
  output logic       read_ready_o
);
  sr_state_e state_q, state_d;
  logic      clk_ok, nop_last, dll_last;
  logic      nop_run, dll_run;

  assign nop_run = (state_q == ST_EXIT_NOP);
  assign dll_run = (state_q == ST_EXIT_NOP) || (state_q == ST_READY);

  sr_clk_qualifier #(.STABLE_CYCLES(STABLE_CYCLES)) u_clk_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (state_q == ST_WAIT_CLK),
    .stable_i (clk_stable_i),
    .ok_o     (clk_ok)
  );

  sr_exit_timer #(.LIMIT(EXIT_NOP_CYCLES)) u_nop_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (nop_run),
    .last_o (nop_last)
  );

  // counts from the first cke-high cycle, across EXIT_NOP and READY
  sr_exit_timer #(.LIMIT(DLL_CYCLES)) u_dll_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (dll_run),
    .last_o (dll_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE:       if (sleep_req_i) state_d = ST_ENTER;
      ST_ENTER:        state_d = ST_SELF_REFRESH;
      ST_SELF_REFRESH: if (wake_req_i) state_d = ST_WAIT_CLK;
      ST_WAIT_CLK:     if (clk_ok) state_d = ST_EXIT_NOP;
      ST_EXIT_NOP:     if (nop_last) state_d = ST_READY;
      ST_READY: begin
        if (sleep_req_i)   state_d = ST_ENTER;
        else if (dll_last) state_d = ST_ACTIVE;
      end
      default:         state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACTIVE;
    else         state_q <= state_d;
  end

  assign cke_o        = !((state_q == ST_ENTER) || (state_q == ST_SELF_REFRESH) ||
                          (state_q == ST_WAIT_CLK));
  assign cmd_o        = (state_q == ST_ENTER) ? CMD_REFRESH : CMD_NOP;
  assign cmd_ready_o  = (state_q == ST_ACTIVE) || (state_q == ST_READY);
  assign read_ready_o = (state_q == ST_ACTIVE);
endmodule

// File: rtl/selfref_seq_chk.sv
module selfref_seq_chk
  import selfref_pkg::*;
#(
  parameter int unsigned EXIT_NOP_CYCLES = 10,
  parameter int unsigned DLL_CYCLES      = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_stable_i,
  input logic       cke_o,
  input logic [2:0] cmd_o,
  input logic       cmd_ready_o,
  input logic       read_ready_o
);
  localparam int unsigned HW = $clog2(DLL_CYCLES + 1);

  logic [HW-1:0] hi_cnt_q;

  // cycles with cke high since it was last low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hi_cnt_q <= '0;
    else if (!cke_o)               hi_cnt_q <= '0;
    else if (hi_cnt_q != HW'(DLL_CYCLES)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assert_ref_then_sr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REFRESH) |=> (cmd_o == CMD_NOP) && !cke_o);

  assert_no_ready_in_sr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> !cmd_ready_o && !read_ready_o);

  assert_cke_after_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> $past(clk_stable_i));

  assert_nop_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> !cmd_ready_o);

  assert_cmd_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_ready_o) |-> (hi_cnt_q >= HW'(EXIT_NOP_CYCLES)));

  assert_dll_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(read_ready_o) |-> (hi_cnt_q >= HW'(DLL_CYCLES)));

  assert_read_implies_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_ready_o |-> cmd_ready_o && cke_o);

  assert_cmd_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_NOP) || (cmd_o == CMD_REFRESH));
endmodule

bind selfref_seq selfref_seq_chk #(
  .EXIT_NOP_CYCLES (EXIT_NOP_CYCLES),
  .DLL_CYCLES      (DLL_CYCLES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_stable_i (clk_stable_i),
  .cke_o        (cke_o),
  .cmd_o        (cmd_o),
  .cmd_ready_o  (cmd_ready_o),
  .read_ready_o (read_ready_o)
);

// File: tb/tb_selfref_seq.sv
`timescale 1ns/1ps
module tb_selfref_seq;
  localparam int STABLE = 4;
  localparam int XNOP   = 10;
  localparam int DLL    = 200;
  localparam logic [2:0] NOP = 3'b111;
  localparam logic [2:0] REF = 3'b001;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_req_i = 1'b0, wake_req_i = 1'b0, clk_stable_i = 1'b0;
  logic cke_o, cmd_ready_o, read_ready_o;
  logic [2:0] cmd_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       cke;
    logic [2:0] cmd;
    logic       cr;
    logic       rr;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  selfref_seq dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_req_i  (sleep_req_i),
    .wake_req_i   (wake_req_i),
    .clk_stable_i (clk_stable_i),
    .cke_o        (cke_o),
    .cmd_o        (cmd_o),
    .cmd_ready_o  (cmd_ready_o),
    .read_ready_o (read_ready_o)
  );

  function automatic exp_t mk(logic cke, logic [2:0] cmd, logic cr, logic rr, string tag);
    exp_t e;
    e.cke = cke; e.cmd = cmd; e.cr = cr; e.rr = rr; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t e_act(string t);  return mk(1'b1, NOP, 1'b1, 1'b1, t); endfunction
  function automatic exp_t e_ent(string t);  return mk(1'b0, REF, 1'b0, 1'b0, t); endfunction
  function automatic exp_t e_low(string t);  return mk(1'b0, NOP, 1'b0, 1'b0, t); endfunction
  function automatic exp_t e_exit(string t); return mk(1'b1, NOP, 1'b0, 1'b0, t); endfunction
  function automatic exp_t e_rdy(string t);  return mk(1'b1, NOP, 1'b1, 1'b0, t); endfunction

  // driver: set inputs for the next edge and queue the outputs expected after it
  task automatic cyc(input logic s, input logic w, input logic st, input exp_t e);
    @(negedge clk_i);
    sleep_req_i  = s;
    wake_req_i   = w;
    clk_stable_i = st;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #5;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (cke_o !== e.cke || cmd_o !== e.cmd || cmd_ready_o !== e.cr || read_ready_o !== e.rr) begin
        errors++;
        $display("FAIL %s: got cke=%b cmd=%b cr=%b rr=%b, expected cke=%b cmd=%b cr=%b rr=%b",
                 e.tag, cke_o, cmd_o, cmd_ready_o, read_ready_o, e.cke, e.cmd, e.cr, e.rr);
      end
    end
  end

  task automatic enter_sr(string tag);
    cyc(1'b1, 1'b0, 1'b0, e_ent(tag));
    cyc(1'b1, 1'b0, 1'b1, e_low("R3"));
    for (int i = 0; i < 5; i++) cyc(i[0], 1'b0, ~i[0], e_low("R3"));
  endtask

  // wake with stable held high; ready_cycles READY cycles before stopping
  task automatic exit_sr(input int ready_cycles, input string dll_tag);
    cyc(1'b0, 1'b1, 1'b1, e_low("R4"));  // stable ignored in this cycle
    for (int i = 0; i < STABLE - 1; i++) cyc(1'b0, 1'b0, 1'b1, e_low("R4"));
    cyc(1'b0, 1'b0, 1'b1, e_exit("R4"));
    for (int i = 1; i < XNOP; i++) cyc(i == 3, 1'b0, 1'b1, e_exit("R5"));
    cyc(1'b0, 1'b0, 1'b1, e_rdy("R6"));
    for (int i = 1; i < ready_cycles; i++) cyc(1'b0, 1'b0, 1'b1, e_rdy(dll_tag));
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (cke_o !== 1'b1 || cmd_o !== NOP || cmd_ready_o !== 1'b1 || read_ready_o !== 1'b1) begin
      errors++;
      $display("FAIL R1: got cke=%b cmd=%b cr=%b rr=%b, expected 1 111 1 1",
               cke_o, cmd_o, cmd_ready_o, read_ready_o);
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, e_act("R1"));
    cyc(1'b0, 1'b1, 1'b1, e_act("R8"));  // wake in normal state ignored
    cyc(1'b0, 1'b0, 1'b0, e_act("R8"));

    // first entry and exit with a stable glitch and stray sleep requests
    enter_sr("R2");
    cyc(1'b0, 1'b1, 1'b0, e_low("R4"));
    for (int i = 0; i < STABLE - 1; i++) cyc(1'b0, 1'b0, 1'b1, e_low("R4"));
    cyc(1'b1, 1'b0, 1'b0, e_low("R8"));  // glitch restarts count, sleep ignored
    for (int i = 0; i < STABLE - 1; i++) cyc(1'b0, 1'b0, 1'b1, e_low("R4"));
    cyc(1'b0, 1'b0, 1'b1, e_exit("R4"));
    for (int i = 1; i < XNOP; i++) cyc(i == 4, 1'b0, 1'b0, e_exit("R5"));
    cyc(1'b0, 1'b0, 1'b0, e_rdy("R6"));
    for (int i = 1; i < DLL - XNOP; i++) cyc(1'b0, 1'b0, 1'b0, e_rdy("R7"));
    cyc(1'b0, 1'b0, 1'b0, e_act("R7"));
    cyc(1'b0, 1'b0, 1'b0, e_act("R7"));

    // second pass, stable already high at wake
    enter_sr("R2");
    exit_sr(50, "R7");
    // re-entry during read lockout
    enter_sr("R10");
    exit_sr(DLL - XNOP, "R10");
    cyc(1'b0, 1'b0, 1'b0, e_act("R10"));
    cyc(1'b0, 1'b1, 1'b0, e_act("R8"));

    @(negedge clk_i);
    @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule